// File: doc/BRIEF.md
# One-Time-Programmable Program Memory Programming Port

This block is the device-side logic for a one-time-programmable program memory while the device sits in programming mode. It has no address bus. An internal address counter is zeroed by a mode command and then moves forward by one location for every fourth rising edge on a dedicated step pin. Four mode pins choose between zeroing the address, writing, verifying and inhibiting. A single enable input stands in for the programming-voltage condition. Without that enable, the port does nothing.

The 8-bit data path is split across two 4-bit port groups. The low group carries bits [3:0] and the high group carries bits [7:4]. Each group is modelled as separate input, output and output-enable signals. During a write the incoming byte is sampled for as long as the write code is held. The byte is committed to the current location when the pins leave the write code. Committing ORs the new ones into the stored byte, because a programmed bit can never be erased. In verify mode the stored byte at the current location is driven onto both groups. In every other mode the groups float.

The array is a behavioural register array. Its depth is a parameter, and the last address is depth minus one. The full-size part uses a depth of 16256, which gives a last address of 0x3F7F. A programmer sequences the mode pins and the step pin to write and verify every location in turn.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the address is 0, both output enables are low and every stored byte reads 0x00.
- R2: The mode code mode[3:0] = 4'b0101 (mode[0] is the first mode pin) sets the address to 0 and also clears the count of step edges, so the next advance needs four fresh rising edges.
- R3: In any enabled write, verify or inhibit mode, the address advances by one on every fourth rising edge of step_pin. Edges one to three leave it unchanged.
- R4: Once the address equals DEPTH-1, further step edges hold it there; it does not wrap to 0.
- R5: The write code 4'b1110 samples {data_hi_in, data_lo_in} on every cycle it is held. When the code is left with prog_en high, the last sampled byte is committed to the current address.
- R6: A commit ORs the sampled byte into the stored byte. A bit at 1 never returns to 0, and writing 0x00 changes nothing.
- R7: The verify code 4'b1100 drives the stored byte of the current address within two cycles. Bits [3:0] go on data_lo_out and bits [7:4] on data_hi_out, and data_lo_oe and data_hi_oe are both high.
- R8: Both output enables are low for the inhibit codes 4'b11?1, the zeroing code, the write code and any unlisted code.
- R9: While prog_en is low, mode pins, step edges and data inputs are ignored. The address and the array are unchanged, and a write pending when prog_en falls is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming condition present |
| mode | input | 4 | Mode pins, mode[0] is the first pin |
| step_pin | input | 1 | Address step clock pin, already synchronous to clk |
| data_lo_in | input | 4 | Low data group input, bits [3:0] |
| data_hi_in | input | 4 | High data group input, bits [7:4] |
| data_lo_out | output | 4 | Low data group output value |
| data_hi_out | output | 4 | High data group output value |
| data_lo_oe | output | 1 | Low data group output enable |
| data_hi_oe | output | 1 | High data group output enable |

## Verification
The assertions assume that mode, step_pin and the data groups are already synchronous to clk. They also assume that each level on step_pin is held for at least one clock, so every rising edge is seen once. The bench meets this by changing all pins on the falling clock edge and holding each step level for two cycles. It also holds the mode code for at least two cycles before reading or switching, so a commit and the registered verify output have settled before they are sampled.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ZERO,
        OP_WRITE,
        OP_VERIFY,
        OP_HOLD
    } prog_op_e;

    localparam logic [3:0] CODE_ZERO   = 4'b0101;
    localparam logic [3:0] CODE_WRITE  = 4'b1110;
    localparam logic [3:0] CODE_VERIFY = 4'b1100;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_prog_pkg::*;
(
    input  logic       prog_en,
    input  logic [3:0] mode,
    output prog_op_e   op
);

    always_comb begin
        op = OP_IDLE;
        if (prog_en) begin
            casez (mode)
                CODE_ZERO:   op = OP_ZERO;
                CODE_WRITE:  op = OP_WRITE;
                CODE_VERIFY: op = OP_VERIFY;
                4'b11?1:     op = OP_HOLD;
                default:     op = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  prog_op_e      op,
    input  logic          step_pin,
    input  logic [7:0]    data_in,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [7:0]    wr_data
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    phase;
        logic          step;
        logic          pend;
        logic [7:0]    wbyte;
    } seq_t;

    seq_t seq_d, seq_q;
    logic step_rise;
    logic counting;

    always_comb begin
        seq_d     = seq_q;
        seq_d.step = step_pin;
        step_rise = step_pin & ~seq_q.step;
        counting  = (op == OP_WRITE) || (op == OP_VERIFY) || (op == OP_HOLD);
        wr_en     = 1'b0;
        wr_data   = seq_q.wbyte;

        if (op == OP_ZERO) begin
            seq_d.addr  = '0;
            seq_d.phase = 2'd0;
        end else if (counting && step_rise) begin
            if (seq_q.phase == 2'd3) begin
                seq_d.phase = 2'd0;
                if (seq_q.addr != LAST_ADDR) begin
                    seq_d.addr = seq_q.addr + 1'b1;
                end
            end else begin
                seq_d.phase = seq_q.phase + 2'd1;
            end
        end

        if (op == OP_WRITE) begin
            seq_d.pend  = 1'b1;
            seq_d.wbyte = data_in;
        end else begin
            seq_d.pend = 1'b0;
            wr_en      = seq_q.pend & prog_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr = seq_q.addr;

    // R4
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.addr <= LAST_ADDR);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.addr != $past(seq_q.addr)) |->
            (seq_q.addr == AW'($past(seq_q.addr) + 1'b1) || seq_q.addr == '0));

    // R2
    zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ZERO) |=> (seq_q.addr == '0 && seq_q.phase == 2'd0));

    // R5
    commit_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(op) == OP_WRITE && op != OP_WRITE));

endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);

    logic [7:0] cells_q [DEPTH];
    logic [7:0] rd_data_d, rd_data_q;
    logic       rd_valid_d, rd_valid_q;

    always_comb begin
        rd_valid_d = rd_en;
        rd_data_d  = rd_en ? cells_q[addr] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= 8'h00;
            end
            rd_data_q  <= 8'h00;
            rd_valid_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cells_q[addr] <= cells_q[addr] | wr_data;
            end
            rd_data_q  <= rd_data_d;
            rd_valid_q <= rd_valid_d;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_q |-> (rd_data_q == 8'h00));

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic [3:0] mode,
    input  logic       step_pin,
    input  logic [3:0] data_lo_in,
    input  logic [3:0] data_hi_in,
    output logic [3:0] data_lo_out,
    output logic [3:0] data_hi_out,
    output logic       data_lo_oe,
    output logic       data_hi_oe
);

    prog_op_e      op;
    logic [AW-1:0] cur_addr;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          rd_valid;

    otp_mode_decode decode_i (
        .prog_en (prog_en),
        .mode    (mode),
        .op      (op)
    );

    otp_addr_seq #(.DEPTH(DEPTH)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .op       (op),
        .step_pin (step_pin),
        .data_in  ({data_hi_in, data_lo_in}),
        .addr     (cur_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    otp_array #(.DEPTH(DEPTH)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (cur_addr),
        .wr_data  (wr_data),
        .rd_en    (op == OP_VERIFY),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign data_lo_out = rd_data[3:0];
    assign data_hi_out = rd_data[7:4];
    assign data_lo_oe  = rd_valid;
    assign data_hi_oe  = rd_valid;

    // R8
    drive_only_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_lo_oe || data_hi_oe) |-> $past(prog_en && mode == CODE_VERIFY));

    // R9
    disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |-> !wr_en);

endmodule

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb_top;

    localparam int DEPTH = 256;
    localparam logic [3:0] M_ZERO   = 4'b0101;
    localparam logic [3:0] M_WRITE  = 4'b1110;
    localparam logic [3:0] M_VERIFY = 4'b1100;
    localparam logic [3:0] M_HOLD   = 4'b1101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic [3:0] mode = 4'b0000;
    logic       step_pin = 1'b0;
    logic [3:0] data_lo_in = 4'h0;
    logic [3:0] data_hi_in = 4'h0;
    logic [3:0] data_lo_out, data_hi_out;
    logic       data_lo_oe, data_hi_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    otp_prog_port #(.DEPTH(DEPTH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_en     (prog_en),
        .mode        (mode),
        .step_pin    (step_pin),
        .data_lo_in  (data_lo_in),
        .data_hi_in  (data_hi_in),
        .data_lo_out (data_lo_out),
        .data_hi_out (data_hi_out),
        .data_lo_oe  (data_lo_oe),
        .data_hi_oe  (data_hi_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            step_pin = 1'b1; cyc(2);
            step_pin = 1'b0; cyc(2);
        end
    endtask

    task automatic read_byte(output logic [7:0] b);
        mode = M_VERIFY;
        cyc(3);
        b = {data_hi_out, data_lo_out};
    endtask

    task automatic write_byte(logic [7:0] b);
        mode = M_WRITE;
        {data_hi_in, data_lo_in} = b;
        cyc(2);
        mode = M_HOLD;
        cyc(2);
    endtask

    task automatic zero_addr();
        mode = M_ZERO;
        cyc(2);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R1 oe after reset", {data_hi_oe, data_lo_oe}, 2'b00);
        prog_en = 1'b1;
        zero_addr();
        read_byte(b);
        check("R1 erased byte", b, 8'h00);
    endtask

    task automatic t_program_and_read();
        logic [7:0] b;
        zero_addr();
        write_byte(8'h3C); pulse(4);
        write_byte(8'hA5); pulse(4);
        write_byte(8'h5A);
        zero_addr();
        mode = M_VERIFY; cyc(3);
        check("R7 oe lo", data_lo_oe, 1'b1);
        check("R7 oe hi", data_hi_oe, 1'b1);
        check("R7 low nibble", data_lo_out, 4'hC);
        check("R7 high nibble", data_hi_out, 4'h3);
        pulse(3);
        read_byte(b);
        check("R3 three edges hold address", b, 8'h3C);
        pulse(1);
        read_byte(b);
        check("R3 fourth edge advances", b, 8'hA5);
        pulse(4);
        read_byte(b);
        check("R5 third location", b, 8'h5A);
    endtask

    task automatic t_last_sample();
        logic [7:0] b;
        zero_addr();
        mode = M_HOLD;
        pulse(12);
        mode = M_WRITE;
        {data_hi_in, data_lo_in} = 8'h11; cyc(2);
        {data_hi_in, data_lo_in} = 8'h80; cyc(2);
        mode = M_HOLD; cyc(2);
        read_byte(b);
        check("R5 last sample committed", b, 8'h80);
    endtask

    task automatic t_or_write();
        logic [7:0] b;
        zero_addr();
        write_byte(8'h42);
        read_byte(b);
        check("R6 bits merged", b, 8'h7E);
        write_byte(8'h00);
        read_byte(b);
        check("R6 zero write no change", b, 8'h7E);
    endtask

    task automatic t_float();
        mode = 4'b1101; cyc(3);
        check("R8 inhibit md1 low", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = 4'b1111; cyc(3);
        check("R8 inhibit md1 high", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = M_ZERO; cyc(3);
        check("R8 zeroing code", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = 4'b0000; cyc(3);
        check("R8 unlisted code", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = M_WRITE; cyc(3);
        check("R8 write code", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = M_HOLD; cyc(2);
    endtask

    task automatic t_disabled();
        logic [7:0] b;
        zero_addr();
        mode = M_HOLD;
        pulse(4);
        read_byte(b);
        check("R9 setup at location 1", b, 8'hA5);
        mode = M_WRITE;
        {data_hi_in, data_lo_in} = 8'hFF;
        cyc(1);
        prog_en = 1'b0;
        cyc(2);
        pulse(8);
        mode = M_VERIFY; cyc(3);
        check("R9 oe while disabled", {data_hi_oe, data_lo_oe}, 2'b00);
        mode = M_ZERO; cyc(2);
        mode = M_VERIFY; cyc(1);
        prog_en = 1'b1;
        cyc(3);
        check("R9 address and byte kept", {data_hi_out, data_lo_out}, 8'hA5);
    endtask

    task automatic t_phase_clear();
        logic [7:0] b;
        zero_addr();
        mode = M_VERIFY;
        pulse(2);
        zero_addr();
        mode = M_VERIFY;
        pulse(3);
        read_byte(b);
        check("R2 phase cleared by zero code", b, 8'h7E);
        pulse(1);
        read_byte(b);
        check("R2 advance after four fresh edges", b, 8'hA5);
    endtask

    task automatic t_saturate();
        logic [7:0] b;
        zero_addr();
        mode = M_HOLD;
        pulse(4 * (DEPTH - 1));
        read_byte(b);
        check("R4 last location erased", b, 8'h00);
        write_byte(8'h77);
        pulse(8);
        read_byte(b);
        check("R4 address holds at end", b, 8'h77);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_program_and_read();
        t_last_sample();
        t_or_write();
        t_float();
        t_disabled();
        t_phase_clear();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule